// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Peripheral Override

This block is a six-pin general-purpose I/O port that sits on a register bus. Software controls it through three registers: a direction register, an output data latch, and a pin-level read port. Each pin has an output-data signal and an output-enable signal that go to a tri-state pad driver. The synchronised pad level comes back on the read path.

Pins 0 to 4 are bidirectional. Pin 5 is input only, and it is masked to 0 whenever the master-clear-enable configuration input is high.

Peripherals can take over any bidirectional pin. They can force the pin to drive or to float, and they can supply its data. Pin 0 also carries a CAN transmit signal, which is selected whenever the CAN operating-mode field is nonzero. None of these overrides ever changes the stored direction bits, so software can read-modify-write the direction register safely while a peripheral owns a pin.

Top module: `gpio6_port`

## Requirements
- R1: After reset the direction register reads 0x3F, the latch reads 0x00, and pin_oe is 0 on every pin.
- R2: For pins 0 to 4 with no override active, a direction bit of 1 gives pin_oe = 0. A direction bit of 0 gives pin_oe = 1 with pin_out equal to the latch bit. A register write takes effect on the clock after the strobe.
- R3: A write on either wr_port or wr_lat loads wdata[4:0] into the latch. A read with rd_lat returns the latch and does not depend on the pin levels.
- R4: A read with rd_port returns the pin_in levels as they were two clocks earlier, through a two-flop synchroniser.
- R5: Bit 5 of a PORT read is 0 while mclr_en = 1. While mclr_en = 0 it is the synchronised pin_in[5].
- R6: Bits 7:6 of every read are 0. Bit 5 reads as 1 in the direction register and as 0 in the latch, and writes to bit 5 have no effect. Pin 5 is never driven: pin_oe[5] = 0.
- R7: While ovr_en[i] = 1 (i in 0..4), pin_oe[i] = ovr_oe[i] and pin_out[i] = ovr_dat[i]. The direction register still reads back the value software wrote.
- R8: When ovr_en[i] falls, pin i returns in the same cycle to the behaviour set by the direction bit and the latch.
- R9: While can_mode != 3'b000, pin 0 drives can_tx with pin_oe[0] = 1. This takes priority over ovr_en[0] and over the direction bit.
- R10: Read selects have the priority rd_port over rd_lat over rd_dir. With no select asserted, rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_port | input | 1 | Write strobe, PORT address |
| wr_lat | input | 1 | Write strobe, latch address |
| wr_dir | input | 1 | Write strobe, direction register |
| rd_port | input | 1 | Read select, pin levels |
| rd_lat | input | 1 | Read select, latch |
| rd_dir | input | 1 | Read select, direction register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Pad output data |
| pin_oe | output | 6 | Pad output enable, 1 = drive |
| ovr_en | input | 5 | Per-pin peripheral override enable |
| ovr_oe | input | 5 | Override output enable |
| ovr_dat | input | 5 | Override output data |
| can_tx | input | 1 | CAN transmit data for pin 0 |
| can_mode | input | 3 | CAN operating mode; nonzero selects can_tx on pin 0 |
| mclr_en | input | 1 | Master-clear enable; 1 masks pin 5 reads to 0 |

## Verification
The bench drives pin levels that differ from the latch, so that a design returning the pins on a latch read, or the latch on a PORT read, gives the wrong value. It holds overrides active and then reads the direction register, to catch a design that stores the override into it. It releases an override and checks the pins in that same cycle. It samples the PORT read one clock early and then exactly on time, so that a synchroniser with the wrong depth is exposed. It also writes all ones to the read-only bits and puts CAN mode and a generic override on pin 0 at the same time, to catch a wrong masking or a wrong priority.

// File: rtl/gpio6_port.sv
module gpio6_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_port,
  input  logic       wr_lat,
  input  logic       wr_dir,
  input  logic       rd_port,
  input  logic       rd_lat,
  input  logic       rd_dir,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [5:0] pin_in,
  output logic [5:0] pin_out,
  output logic [5:0] pin_oe,
  input  logic [4:0] ovr_en,
  input  logic [4:0] ovr_oe,
  input  logic [4:0] ovr_dat,
  input  logic       can_tx,
  input  logic [2:0] can_mode,
  input  logic       mclr_en
);
  logic [4:0] dir_q;
  logic [4:0] lat_q;
  logic [5:0] sync_q [SYNC_STAGES];
  logic [4:0] oe_mix, dat_mix;
  logic       can_on;
  logic [5:0] port_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata[4:0];
      if (wr_port || wr_lat) lat_q <= wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign can_on  = (can_mode != 3'b000);
  assign oe_mix  = (ovr_en & ovr_oe)  | (~ovr_en & ~dir_q);
  assign dat_mix = (ovr_en & ovr_dat) | (~ovr_en & lat_q);

  assign pin_oe  = {1'b0, oe_mix[4:1],  can_on ? 1'b1   : oe_mix[0]};
  assign pin_out = {1'b0, dat_mix[4:1], can_on ? can_tx : dat_mix[0]};

  assign port_val = {sync_q[SYNC_STAGES-1][5] & ~mclr_en, sync_q[SYNC_STAGES-1][4:0]};

  always_comb begin
    if (rd_port)     rdata = {2'b00, port_val};
    else if (rd_lat) rdata = {3'b000, lat_q};
    else if (rd_dir) rdata = {3'b001, dir_q};
    else             rdata = 8'h00;
  end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_port,
  input logic       wr_lat,
  input logic       wr_dir,
  input logic       rd_port,
  input logic       rd_lat,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [5:0] pin_in,
  input logic [5:0] pin_out,
  input logic [5:0] pin_oe,
  input logic [4:0] ovr_en,
  input logic       can_tx,
  input logic [2:0] can_mode,
  input logic       mclr_en
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !wr_port && !wr_lat) |=> ((ovr_en == 5'd0 && can_mode == 3'd0) -> (pin_oe[4:0] == ~$past(wdata[4:0]))));
  // R3
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lat || wr_port) && !wr_dir) |=> ((rd_lat && !rd_port) -> (rdata == {3'b000, $past(wdata[4:0])})));
  // R4
  port_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && rd_port && !mclr_en) |-> (rdata[5:0] == $past(pin_in, 2)));
  // R5
  mclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_port && mclr_en) |-> (rdata[5] == 1'b0));
  // R6
  pin5_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[5] == 1'b0) && (rdata[7:6] == 2'b00));
  // R9
  can_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_mode != 3'd0) |-> (pin_oe[0] && pin_out[0] == can_tx));
endmodule

bind gpio6_port gpio6_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .wr_lat(wr_lat), .wr_dir(wr_dir),
  .rd_port(rd_port), .rd_lat(rd_lat), .wdata(wdata), .rdata(rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ovr_en(ovr_en),
  .can_tx(can_tx), .can_mode(can_mode), .mclr_en(mclr_en)
);

// File: tb/gpio6_port_tb.sv
module gpio6_port_tb;
  logic clk = 0, rst_n = 0;
  logic wr_port = 0, wr_lat = 0, wr_dir = 0, rd_port = 0, rd_lat = 0, rd_dir = 0;
  logic [7:0] wdata = 0, rdata;
  logic [5:0] pin_in = 0, pin_out, pin_oe;
  logic [4:0] ovr_en = 0, ovr_oe = 0, ovr_dat = 0;
  logic can_tx = 0, mclr_en = 1;
  logic [2:0] can_mode = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gpio6_port u_dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    wr_port = (which == 0); wr_lat = (which == 1); wr_dir = (which == 2);
    @(negedge clk);
    wr_port = 0; wr_lat = 0; wr_dir = 0;
  endtask

  task automatic rd(input int which, output logic [7:0] v);
    rd_port = (which == 0); rd_lat = (which == 1); rd_dir = (which == 2);
    #1 v = rdata;
    rd_port = 0; rd_lat = 0; rd_dir = 0;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2, v); chk("R1 dir", v, 8'h3F);
    rd(1, v); chk("R1 lat", v, 8'h00);
    chk("R1 oe", {2'b0, pin_oe}, 8'h00);
    chk("R10 idle", rdata, 8'h00);
  endtask

  task automatic t_dir_lat;
    logic [7:0] v;
    wr(1, 8'h15);
    wr(2, 8'hF0);
    chk("R2 oe", {2'b0, pin_oe}, 8'h0F);
    chk("R2 out", {2'b0, pin_out} & 8'h0F, 8'h05);
    pin_in = 6'h2A;
    rd(1, v); chk("R3 lat", v, 8'h15);
    wr(0, 8'h0A);
    rd(1, v); chk("R3 port write", v, 8'h0A);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pin_in = 6'h13; mclr_en = 0;
    @(negedge clk);
    rd(0, v); chk("R4 early", v, 8'h2A);
    @(negedge clk);
    rd(0, v); chk("R4 on time", v, 8'h13);
    pin_in = 6'h20;
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R5 open", v, 8'h20);
    mclr_en = 1; #1;
    rd(0, v); chk("R5 masked", v, 8'h00);
  endtask

  task automatic t_ro;
    logic [7:0] v;
    wr(2, 8'hC0);
    rd(2, v); chk("R6 dir", v, 8'h20);
    wr(1, 8'hFF);
    rd(1, v); chk("R6 lat", v, 8'h1F);
    chk("R6 oe5", {7'b0, pin_oe[5]}, 8'h00);
    rd_port = 1; rd_lat = 1; rd_dir = 1; #1;
    chk("R10 prio", rdata, 8'h00);
    rd_port = 0; #1;
    chk("R10 lat", rdata, 8'h1F);
    rd_lat = 0; rd_dir = 0; #1;
  endtask

  task automatic t_ovr;
    logic [7:0] v;
    wr(2, 8'h1F);
    wr(1, 8'h00);
    @(negedge clk);
    ovr_en = 5'h06; ovr_oe = 5'h06; ovr_dat = 5'h02; #1;
    chk("R7 oe", {2'b0, pin_oe}, 8'h06);
    chk("R7 out", {2'b0, pin_out}, 8'h02);
    rd(2, v); chk("R7 dir kept", v, 8'h3F);
    wr(2, 8'h00);
    chk("R7 held", {2'b0, pin_oe}, 8'h1F);
    ovr_oe = 5'h00; #1;
    chk("R7 force in", {2'b0, pin_oe}, 8'h19);
    ovr_en = 0; #1;
    chk("R8 release", {2'b0, pin_oe}, 8'h1F);
    chk("R8 data", {2'b0, pin_out}, 8'h00);
  endtask

  task automatic t_can;
    wr(2, 8'h1F);
    ovr_en = 5'h01; ovr_oe = 5'h00; ovr_dat = 5'h00;
    can_mode = 3'b010; can_tx = 1; #1;
    chk("R9 oe", {7'b0, pin_oe[0]}, 8'h01);
    chk("R9 tx1", {7'b0, pin_out[0]}, 8'h01);
    can_tx = 0; #1;
    chk("R9 tx0", {7'b0, pin_out[0]}, 8'h00);
    can_mode = 0; #1;
    chk("R9 off", {7'b0, pin_oe[0]}, 8'h00);
    ovr_en = 0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_dir_lat; t_sync; t_ro; t_ovr; t_can;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule